// File: doc/BRIEF.md
# Fault-Map Line Cache and Lookup

This block answers one question for a memory controller: does the 64-byte data line at a given address hold faulty words, and does it need a second, replicated copy? The answer comes from a packed fault map held in memory. Each data line has a 4-bit descriptor, and one 64-byte fault-map line carries the descriptors of 128 consecutive data lines. The block keeps a small direct-mapped cache of fault-map lines on chip, so most lookups avoid a second trip to memory.

A lookup presents a data line address. The block splits the address into a fault-map group, which is the address divided by 128, and an entry index, which is the address modulo 128. It then probes the cache. On a hit the descriptor comes back on the next cycle. On a miss the block issues one fetch of the fault-map line at `fm_base + group`, waits for the data, installs the line, and answers from the fetched bits. Only one miss can be outstanding, and new requests are held off with `req_ready` until it resolves. When software rewrites part of the fault map, it names the affected group on the invalidate input, and any cached copy of that group is dropped.

Top module: `fmap_lookup`

## Requirements
- R1: A synchronous reset leaves every cache slot invalid, `req_ready` high, and both `resp_valid` and `mem_req_valid` low, so the first lookup after reset is a miss.
- R2: The entry index is `req_addr[6:0]` and selects bits `[4*idx+3 : 4*idx]` of the fault-map line. The group is `req_addr >> 7`, and a fetch is issued at address `fm_base + group`.
- R3: A request accepted while its group is cached gives `resp_valid` with `resp_miss = 0` on the next cycle and issues no fetch.
- R4: A request accepted while its group is not cached raises `mem_req_valid` on the next cycle and holds it, with a stable address, until `mem_req_ready` is seen.
- R5: The response to a miss arrives on the cycle after `mem_rsp_valid`, with `resp_miss = 1` and the descriptor taken from `mem_rsp_data`. The line is then installed, so later lookups in the same group hit.
- R6: `resp_faulty` is 1 exactly when the descriptor is nonzero, and `resp_replicated` is bit 0 of the descriptor.
- R7: Only one miss is outstanding at a time. `req_ready` stays low from the acceptance of a miss until its response cycle, and responses leave in the order in which requests were accepted.
- R8: Group g lives in slot g mod 16. Filling a slot evicts the group it held before, and that group then misses.
- R9: An invalidate names a group. It clears the slot only if that slot holds that group, and leaves other cached groups hitting.
- R10: An invalidate in the same cycle as a lookup of the same cached group turns the lookup into a miss.
- R11: An invalidate of the group being fetched, issued while the fetch is outstanding, still lets the fill answer its request, but the line is not installed and the next lookup of that group misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fm_base | input | ADDR_W | Base address of the fault-map table, in 64-byte line units |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a lookup |
| req_addr | input | ADDR_W | Data line address to look up |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_entry | output | ENTRY_W | 4-bit fault descriptor of the line |
| resp_faulty | output | 1 | Line holds at least one faulty word |
| resp_replicated | output | 1 | Line has a replicated copy (descriptor bit 0) |
| resp_miss | output | 1 | Response was served by a fetch |
| mem_req_valid | output | 1 | Fault-map line fetch request |
| mem_req_ready | input | 1 | Memory accepts the fetch |
| mem_req_addr | output | ADDR_W | Fault-map line address to fetch |
| mem_rsp_valid | input | 1 | Fetched line is present |
| mem_rsp_data | input | LINE_W | Fetched fault-map line |
| inval_valid | input | 1 | Invalidate strobe |
| inval_group | input | ADDR_W-7 | Group whose fault map was rewritten |

## Verification
A wrong valid bit or tag shows up on the very next lookup of the affected group. A stale slot answers with `resp_miss = 0` where a fetch was due, and a lost line causes an extra `mem_req_valid`. In both cases the error is visible one cycle after acceptance. A wrong index or field split returns a descriptor that differs from the computed table on the response cycle, and a broken miss sequencer shows `req_ready` or `mem_req_valid` out of step within the same cycle. The bench runs a cycle model next to the block and compares every output on every clock, through directed eviction and invalidate races and then a long stream of colliding addresses.

// File: rtl/fmap_lookup.sv
module fmap_lookup #(
  parameter int ADDR_W  = 32,
  parameter int SLOTS   = 16,
  parameter int ENTRY_W = 4,
  parameter int LINE_W  = 512
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   fm_base,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  output logic                resp_valid,
  output logic [ENTRY_W-1:0]  resp_entry,
  output logic                resp_faulty,
  output logic                resp_replicated,
  output logic                resp_miss,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [ADDR_W-1:0]   mem_req_addr,
  input  logic                mem_rsp_valid,
  input  logic [LINE_W-1:0]   mem_rsp_data,
  input  logic                inval_valid,
  input  logic [ADDR_W-$clog2(LINE_W/ENTRY_W)-1:0] inval_group
);
  localparam int ENTRIES = LINE_W / ENTRY_W;
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int SLOT_W  = $clog2(SLOTS);
  localparam int GRP_W   = ADDR_W - IDX_W;
  localparam int TAG_W   = GRP_W - SLOT_W;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} state_t;
  state_t state;

  logic [LINE_W-1:0] lines [SLOTS];
  logic [TAG_W-1:0]  tags  [SLOTS];
  logic [SLOTS-1:0]  vld;

  logic [GRP_W-1:0] pend_grp;
  logic [IDX_W-1:0] pend_idx;
  logic             stale;

  wire [GRP_W-1:0]  req_grp  = req_addr[ADDR_W-1:IDX_W];
  wire [IDX_W-1:0]  req_idx  = req_addr[IDX_W-1:0];
  wire [SLOT_W-1:0] req_slot = req_grp[SLOT_W-1:0];
  wire [SLOT_W-1:0] inv_slot = inval_group[SLOT_W-1:0];
  wire [SLOT_W-1:0] pend_slot = pend_grp[SLOT_W-1:0];

  wire inv_on_req  = inval_valid && (inval_group == req_grp);
  wire inv_on_pend = inval_valid && (inval_group == pend_grp);
  wire hit    = vld[req_slot] && (tags[req_slot] == req_grp[GRP_W-1:SLOT_W]) && !inv_on_req;
  wire accept = req_valid && req_ready;
  wire fill   = (state == S_WAIT) && mem_rsp_valid;

  wire [ENTRY_W-1:0] hit_entry  = lines[req_slot][int'(req_idx)*ENTRY_W +: ENTRY_W];
  wire [ENTRY_W-1:0] fill_entry = mem_rsp_data[int'(pend_idx)*ENTRY_W +: ENTRY_W];

  assign req_ready       = (state == S_IDLE);
  assign mem_req_valid   = (state == S_REQ);
  assign resp_faulty     = |resp_entry;
  assign resp_replicated = resp_entry[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      stale    <= 1'b0;
      pend_grp <= '0;
      pend_idx <= '0;
      mem_req_addr <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept && !hit) begin
          state        <= S_REQ;
          pend_grp     <= req_grp;
          pend_idx     <= req_idx;
          stale        <= 1'b0;
          mem_req_addr <= fm_base + ADDR_W'(req_grp);
        end
        S_REQ:  if (mem_req_ready) state <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
      if (state != S_IDLE && inv_on_pend) stale <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else begin
      if (inval_valid && vld[inv_slot] && tags[inv_slot] == inval_group[GRP_W-1:SLOT_W])
        vld[inv_slot] <= 1'b0;
      if (fill)
        vld[pend_slot] <= !(stale || inv_on_pend);
    end
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      lines[pend_slot] <= mem_rsp_data;
      tags[pend_slot]  <= pend_grp[GRP_W-1:SLOT_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_entry <= '0;
      resp_miss  <= 1'b0;
    end else begin
      resp_valid <= fill || (accept && hit);
      resp_miss  <= fill;
      if (fill)               resp_entry <= fill_entry;
      else if (accept && hit) resp_entry <= hit_entry;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!resp_valid && !mem_req_valid && req_ready));
  assert_fetch_held_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  assert_single_fetch_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_ready) |=> (!mem_req_valid && !req_ready));
  assert_accept_outcome_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (resp_valid ^ mem_req_valid));
  assert_resp_cause_R5: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> ($past(req_valid && req_ready) || $past(mem_rsp_valid)));
  assert_miss_after_data_R5: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_miss) |-> $past(mem_rsp_valid));
endmodule

// File: tb/fmap_lookup_test.sv
module fmap_lookup_test;
  logic clk = 0, rst = 1;
  logic [31:0] fm_base = 32'h1000;
  logic req_valid = 0, req_ready;
  logic [31:0] req_addr = 0;
  logic resp_valid, resp_faulty, resp_replicated, resp_miss;
  logic [3:0] resp_entry;
  logic mem_req_valid, mem_req_ready = 0;
  logic [31:0] mem_req_addr;
  logic mem_rsp_valid = 0;
  logic [511:0] mem_rsp_data = 0;
  logic inval_valid = 0;
  logic [24:0] inval_group = 0;

  always #5 clk = ~clk;

  fmap_lookup uut (.*);

  int checks = 0, fails = 0;
  string cur_tag = "R5";
  bit armed = 0;

  function automatic int ent(int g, int i);
    int e = (g * 37 + i * 11) % 23;
    return (e < 8) ? 0 : e - 7;
  endfunction

  function automatic logic [511:0] fm_line(int g);
    logic [511:0] l;
    for (int i = 0; i < 128; i++) l[i*4 +: 4] = 4'(ent(g, i));
    return l;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  bit mvalid [16];
  int mtag [16];
  int mstate = 0, pg = 0, pi = 0;
  bit pstale = 0;
  string ptag = "R5";
  bit e_rv = 0, e_miss = 0;
  int e_ent = 0, e_addr = 0;
  string e_tag = "R5";

  always @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < 16; s++) mvalid[s] = 0;
      mstate = 0; e_rv = 0;
    end else begin
      int ps, g, i, s;
      bit filled;
      ps = mstate; filled = 0; e_rv = 0;
      if (ps != 0 && inval_valid && int'(inval_group) == pg) pstale = 1;
      case (ps)
        0: if (req_valid) begin
          g = int'(req_addr >> 7); i = int'(req_addr % 128); s = g % 16;
          if (mvalid[s] && mtag[s] == g && !(inval_valid && int'(inval_group) == g)) begin
            e_rv = 1; e_ent = ent(g, i); e_miss = 0; e_tag = cur_tag;
          end else begin
            mstate = 1; pg = g; pi = i; pstale = 0; ptag = cur_tag;
            e_addr = int'(fm_base) + g;
          end
        end
        1: if (mem_req_ready) mstate = 2;
        default: if (mem_rsp_valid) begin
          e_rv = 1; e_ent = ent(pg, pi); e_miss = 1; e_tag = ptag; mstate = 0; filled = 1;
        end
      endcase
      s = int'(inval_group) % 16;
      if (inval_valid && mvalid[s] && mtag[s] == int'(inval_group)) mvalid[s] = 0;
      if (filled) begin
        mvalid[pg % 16] = !pstale;
        mtag[pg % 16] = pg;
      end
    end
  end

  always @(negedge clk) begin
    if (armed && !rst) begin
      check(req_ready == (mstate == 0), "R7", "req_ready", int'(req_ready), int'(mstate == 0));
      check(resp_valid == e_rv, "R3", "resp_valid", int'(resp_valid), int'(e_rv));
      check(mem_req_valid == (mstate == 1), "R4", "mem_req_valid", int'(mem_req_valid), int'(mstate == 1));
      if (mstate == 1)
        check(int'(mem_req_addr) == e_addr, "R2", "mem_req_addr", int'(mem_req_addr), e_addr);
      if (e_rv) begin
        check(int'(resp_entry) == e_ent, "R2", "resp_entry", int'(resp_entry), e_ent);
        check(resp_miss == e_miss, e_tag, "resp_miss", int'(resp_miss), int'(e_miss));
        check(resp_faulty == (e_ent != 0), "R6", "resp_faulty", int'(resp_faulty), int'(e_ent != 0));
        check(resp_replicated == e_ent[0], "R6", "resp_replicated", int'(resp_replicated), int'(e_ent[0]));
      end
    end
  end

  int mphase = 0, mcnt = 0, mgrp = 0, nfetch = 0;
  initial begin
    forever begin
      @(negedge clk);
      mem_req_ready = 0; mem_rsp_valid = 0;
      if (mphase == 0 && mem_req_valid) begin
        mcnt++;
        if (mcnt > nfetch % 3) begin
          mem_req_ready = 1; mgrp = int'(mem_req_addr - fm_base);
          mphase = 1; mcnt = 0; nfetch++;
        end
      end else if (mphase == 1) begin
        mcnt++;
        if (mcnt >= 2) begin
          mem_rsp_valid = 1; mem_rsp_data = fm_line(mgrp); mphase = 0; mcnt = 0;
        end
      end
    end
  end

  task automatic lookup(int a, string tag, bit inv = 0, int ig = 0);
    bit acc;
    @(negedge clk);
    req_valid = 1; req_addr = 32'(a); cur_tag = tag;
    inval_valid = inv; inval_group = 25'(ig);
    forever begin
      acc = req_ready;
      @(negedge clk);
      inval_valid = 0;
      if (acc) break;
    end
    req_valid = 0;
  endtask

  task automatic invalidate(int g);
    @(negedge clk);
    inval_valid = 1; inval_group = 25'(g);
    @(negedge clk);
    inval_valid = 0;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    report();
  end

  initial begin
    int x;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(req_ready == 1, "R1", "req_ready after reset", int'(req_ready), 1);
    check(resp_valid == 0, "R1", "resp_valid after reset", int'(resp_valid), 0);
    check(mem_req_valid == 0, "R1", "mem_req_valid after reset", int'(mem_req_valid), 0);
    armed = 1;
    lookup(5 * 128 + 3, "R1");
    lookup(5 * 128 + 0, "R3");
    lookup(5 * 128 + 127, "R3");
    lookup(5 * 128 + 64, "R5");
    lookup(6 * 128 + 9, "R5");
    lookup(6 * 128 + 10, "R7");
    lookup(7 * 128 + 1, "R7");
    settle();
    lookup(21 * 128 + 2, "R8");
    lookup(5 * 128 + 2, "R8");
    settle();
    invalidate(5);
    lookup(5 * 128 + 7, "R9");
    lookup(6 * 128 + 7, "R9");
    invalidate(22);
    lookup(6 * 128 + 8, "R9");
    settle();
    lookup(6 * 128 + 11, "R10", 1, 6);
    settle();
    lookup(40 * 128 + 5, "R11");
    invalidate(40);
    settle();
    lookup(40 * 128 + 6, "R11");
    lookup(40 * 128 + 7, "R3");
    settle();
    fm_base = 32'h0002_0000;
    lookup(57 * 128 + 33, "R2");
    settle();
    fm_base = 32'h1000;
    x = 7;
    for (int n = 0; n < 300; n++) begin
      x = x * 1103515245 + 12345;
      lookup((((x >>> 8) & 32'h7fffffff) % 40) * 128 + ((x >>> 20) & 127), "R5");
      if (n % 37 == 0) invalidate(((x >>> 4) & 32'hffff) % 40);
    end
    settle();
    report();
  end
endmodule